// File: doc/BRIEF.md
# Operand Register Select and Autoincrement Unit

This unit sits beside the scratch-pad register file of a 16-bit microcoded processor and prepares operand addressing. Each cycle it picks a 3-bit register number from one of four places: the source field of the instruction, the destination field of the instruction, a constant carried in the microword, or the program counter.

It adds the autoincrement step to the register value read from the file. The step is one for byte operations and two for word operations. The stack pointer (register 6) and the program counter (register 7) always step by two. The unit also sign-extends the low byte of the instruction, which the microcode uses as a branch offset.

All three results are captured in an output register by default. In that mode they appear one clock after the inputs. A parameter can remove that stage so the outputs follow the inputs with no clock delay.

Top module: `opr_addr_unit`

## Requirements
- R1: With select code 0, the register index equals instruction bits 8:6.
- R2: With select code 1, the register index equals instruction bits 2:0.
- R3: With select code 2, the register index equals the microword constant index.
- R4: With select code 3, the register index is 7, the program counter.
- R5: When the byte flag is 1 and the chosen index is 0 to 5, the increment output is the register data plus 1.
- R6: When the byte flag is 0, or the chosen index is 6 or 7, the increment output is the register data plus 2.
- R7: The increment wraps modulo 2^16. For example, 16'hFFFF plus 2 gives 16'h0001, and 16'hFFFF plus 1 gives 16'h0000.
- R8: The sign-extend output copies instruction bits 7:0 into bits 7:0, and copies instruction bit 7 into bits 15:8.
- R9: While reset is high, every output is zero at the next clock edge. With the default output register, each output reflects the inputs that were present at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 16 | Instruction register contents |
| sel | input | 2 | Index source: 0 source field, 1 destination field, 2 constant, 3 PC |
| const_idx | input | 3 | Register number taken from the microword |
| byte_op | input | 1 | 1 for a byte instruction |
| rd_data | input | 16 | Value read from the selected scratch-pad register |
| reg_idx | output | 3 | Chosen register number |
| inc_out | output | 16 | Register value plus the autoincrement step |
| sext_out | output | 16 | Sign-extended low byte of the instruction |

## Verification
The hardest case to reach is the byte override, where the byte flag is 1 but the step must still be 2. It only happens when the chosen index is 6 or 7. That index can come from any of the four select paths, so the override has to be reached through every one of them. The stimulus covers this by sweeping every select code, every register number in each field, and both values of the byte flag. The register data is set near 16'hFFFF on some cycles so that the wrap occurs on both step sizes.

// File: rtl/opr_pkg.sv
package opr_pkg;
  localparam int DATA_W = 16;
  localparam int IDX_W  = 3;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SEL_SRC = 2'd0,
    SEL_DST = 2'd1,
    SEL_CON = 2'd2,
    SEL_PC  = 2'd3
  } sel_e;
endpackage

// File: rtl/opr_idx_mux.sv
module opr_idx_mux #(
  parameter int DW      = 16,
  parameter int RW      = 3,
  parameter int SRC_LSB = 6,
  parameter int DST_LSB = 0,
  parameter int PC_IDX  = 7
) (
  input  logic [DW-1:0] instr,
  input  logic [1:0]    sel,
  input  logic [RW-1:0] const_idx,
  output logic [RW-1:0] idx
);
  always_comb begin
    unique case (opr_pkg::sel_e'(sel))
      opr_pkg::SEL_SRC: idx = instr[SRC_LSB +: RW];
      opr_pkg::SEL_DST: idx = instr[DST_LSB +: RW];
      opr_pkg::SEL_CON: idx = const_idx;
      default:          idx = RW'(PC_IDX);
    endcase
  end
endmodule

// File: rtl/opr_autoinc.sv
module opr_autoinc #(
  parameter int DW     = 16,
  parameter int RW     = 3,
  parameter int SP_IDX = 6,
  parameter int PC_IDX = 7
) (
  input  logic [RW-1:0] idx,
  input  logic          byte_op,
  input  logic [DW-1:0] rd_data,
  output logic [DW-1:0] inc
);
  localparam logic [DW-1:0] STEP_B = DW'(1);
  localparam logic [DW-1:0] STEP_W = DW'(2);

  logic wide;
  logic [DW-1:0] step;

  always_comb begin
    wide = !byte_op || (idx == RW'(SP_IDX)) || (idx == RW'(PC_IDX));
    step = wide ? STEP_W : STEP_B;
    inc  = rd_data + step;
  end
endmodule

// File: rtl/opr_sext.sv
module opr_sext #(
  parameter int DW = 16,
  parameter int BW = 8
) (
  input  logic [BW-1:0] lo,
  output logic [DW-1:0] ext
);
  assign ext = {{(DW-BW){lo[BW-1]}}, lo};
endmodule

// File: rtl/opr_addr_unit.sv
module opr_addr_unit #(
  parameter int DW      = opr_pkg::DATA_W,
  parameter int RW      = opr_pkg::IDX_W,
  parameter int BW      = opr_pkg::BYTE_W,
  parameter int SRC_LSB = 6,
  parameter int DST_LSB = 0,
  parameter int SP_IDX  = 6,
  parameter int PC_IDX  = 7,
  parameter bit OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [15:0]   instr,
  input  logic [1:0]    sel,
  input  logic [2:0]    const_idx,
  input  logic          byte_op,
  input  logic [15:0]   rd_data,
  output logic [2:0]    reg_idx,
  output logic [15:0]   inc_out,
  output logic [15:0]   sext_out
);
  logic [RW-1:0] idx_c;
  logic [DW-1:0] inc_c;
  logic [DW-1:0] sext_c;

  opr_idx_mux #(.DW(DW), .RW(RW), .SRC_LSB(SRC_LSB), .DST_LSB(DST_LSB),
                .PC_IDX(PC_IDX)) u_mux (
    .instr(instr), .sel(sel), .const_idx(const_idx), .idx(idx_c)
  );

  opr_autoinc #(.DW(DW), .RW(RW), .SP_IDX(SP_IDX), .PC_IDX(PC_IDX)) u_inc (
    .idx(idx_c), .byte_op(byte_op), .rd_data(rd_data), .inc(inc_c)
  );

  opr_sext #(.DW(DW), .BW(BW)) u_sext (
    .lo(instr[BW-1:0]), .ext(sext_c)
  );

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          reg_idx  <= '0;
          inc_out  <= '0;
          sext_out <= '0;
        end else begin
          reg_idx  <= idx_c;
          inc_out  <= inc_c;
          sext_out <= sext_c;
        end
      end
    end else begin : g_comb
      assign reg_idx  = idx_c;
      assign inc_out  = inc_c;
      assign sext_out = sext_c;
    end
  endgenerate
endmodule

// File: rtl/opr_addr_unit_chk.sv
module opr_addr_unit_chk #(
  parameter bit OUT_REG = 1'b1
) (
  input logic        clk,
  input logic        rst,
  input logic [15:0] instr,
  input logic [1:0]  sel,
  input logic [2:0]  const_idx,
  input logic        byte_op,
  input logic [15:0] rd_data,
  input logic [2:0]  reg_idx,
  input logic [15:0] inc_out,
  input logic [15:0] sext_out
);
  generate
    if (OUT_REG) begin : g_seq
      AST_SRC_FIELD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(sel) == 2'd0) |-> reg_idx == $past(instr[8:6])); // R1
      AST_DST_FIELD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(sel) == 2'd1) |-> reg_idx == $past(instr[2:0])); // R2
      AST_CONST_FIELD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(sel) == 2'd2) |-> reg_idx == $past(const_idx)); // R3
      AST_PC_FIXED: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(sel) == 2'd3) |-> reg_idx == 3'd7); // R4
      AST_BYTE_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(byte_op) && reg_idx < 3'd6)
          |-> inc_out == 16'($past(rd_data) + 16'd1)); // R5
      AST_WORD_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (!$past(byte_op) || reg_idx >= 3'd6))
          |-> inc_out == 16'($past(rd_data) + 16'd2)); // R6
      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(rd_data) == 16'hFFFF && !$past(byte_op))
          |-> inc_out == 16'h0001); // R7
      AST_SEXT: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> sext_out == {{8{$past(instr[7])}}, $past(instr[7:0])}); // R8
    end else begin : g_comb
      AST_PC_FIXED: assert property (@(posedge clk) disable iff (rst)
        sel == 2'd3 |-> reg_idx == 3'd7); // R4
      AST_SEXT: assert property (@(posedge clk) disable iff (rst)
        sext_out == {{8{instr[7]}}, instr[7:0]}); // R8
      AST_WORD_STEP: assert property (@(posedge clk) disable iff (rst)
        !byte_op |-> inc_out == 16'(rd_data + 16'd2)); // R6
      AST_BYTE_STEP: assert property (@(posedge clk) disable iff (rst)
        (byte_op && reg_idx < 3'd6) |-> inc_out == 16'(rd_data + 16'd1)); // R5
    end
  endgenerate
endmodule

bind opr_addr_unit opr_addr_unit_chk #(.OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rst(rst), .instr(instr), .sel(sel), .const_idx(const_idx),
  .byte_op(byte_op), .rd_data(rd_data), .reg_idx(reg_idx),
  .inc_out(inc_out), .sext_out(sext_out)
);

// File: tb/opr_addr_unit_tb.sv
module opr_addr_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instr = '0;
  logic [1:0]  sel = '0;
  logic [2:0]  const_idx = '0;
  logic        byte_op = 1'b0;
  logic [15:0] rd_data = '0;
  logic [2:0]  reg_idx;
  logic [15:0] inc_out;
  logic [15:0] sext_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  opr_addr_unit u_dut (
    .clk(clk), .rst(rst), .instr(instr), .sel(sel), .const_idx(const_idx),
    .byte_op(byte_op), .rd_data(rd_data), .reg_idx(reg_idx),
    .inc_out(inc_out), .sext_out(sext_out)
  );

  function automatic logic [2:0] ref_idx(logic [1:0] s, logic [15:0] ir, logic [2:0] c);
    case (s)
      2'd0: return ir[8:6];
      2'd1: return ir[2:0];
      2'd2: return c;
      default: return 3'd7;
    endcase
  endfunction

  function automatic logic [15:0] ref_inc(logic [2:0] i, logic b, logic [15:0] d);
    logic [16:0] w;
    w = {1'b0, d} + ((b && i < 3'd6) ? 17'd1 : 17'd2);
    return w[15:0];
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, result registered at next posedge, sample at following negedge
  task automatic apply(logic [15:0] ir, logic [1:0] s, logic [2:0] c, logic b, logic [15:0] d);
    @(negedge clk);
    instr = ir; sel = s; const_idx = c; byte_op = b; rd_data = d;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    apply(16'hFFFF, 2'd3, 3'd5, 1'b1, 16'h1234);
    check("R9 reset idx", {13'd0, reg_idx}, 16'h0);
    check("R9 reset inc", inc_out, 16'h0);
    check("R9 reset sext", sext_out, 16'h0);
    rst = 1'b0;
  endtask

  task automatic t_sweep();
    for (int s = 0; s < 4; s++) begin
      for (int n = 0; n < 8; n++) begin
        for (int b = 0; b < 2; b++) begin
          logic [15:0] ir;
          logic [15:0] d;
          logic [2:0]  ei;
          string       rq;
          ir = {7'h55, 3'(n), 3'b010, 3'(7 - n)};
          d  = 16'h1000 + 16'(n * 37 + s * 5 + b);
          apply(ir, 2'(s), 3'(n ^ 3), 1'(b), d);
          ei = ref_idx(2'(s), ir, 3'(n ^ 3));
          rq = (s == 0) ? "R1" : (s == 1) ? "R2" : (s == 2) ? "R3" : "R4";
          check(rq, {13'd0, reg_idx}, {13'd0, ei});
          check((b == 1 && ei < 3'd6) ? "R5 byte step" : "R6 word step",
                inc_out, ref_inc(ei, 1'(b), d));
        end
      end
    end
  endtask

  task automatic t_wrap();
    apply(16'h0000, 2'd2, 3'd1, 1'b0, 16'hFFFF);
    check("R7 word wrap", inc_out, 16'h0001);
    apply(16'h0000, 2'd2, 3'd1, 1'b1, 16'hFFFF);
    check("R7 byte wrap", inc_out, 16'h0000);
    apply(16'h0000, 2'd3, 3'd1, 1'b1, 16'hFFFF);
    check("R7 pc wrap", inc_out, 16'h0001);
    apply(16'h0000, 2'd2, 3'd6, 1'b1, 16'hFFFE);
    check("R7 sp wrap", inc_out, 16'h0000);
  endtask

  task automatic t_sext();
    logic [7:0] pats [6] = '{8'h00, 8'h7F, 8'h80, 8'hFF, 8'h01, 8'hA5};
    foreach (pats[k]) begin
      apply({8'hC3, pats[k]}, 2'd0, 3'd0, 1'b0, 16'h0);
      check("R8 sext", sext_out, {{8{pats[k][7]}}, pats[k]});
    end
  endtask

  task automatic t_latency();
    apply(16'h01C0, 2'd0, 3'd0, 1'b0, 16'h0010);
    @(negedge clk);
    instr = 16'h0080; sel = 2'd1;
    #1;
    check("R9 held until edge", {13'd0, reg_idx}, 16'h0007);
    @(negedge clk);
    check("R9 updated after edge", {13'd0, reg_idx}, 16'h0000);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_sweep();
    t_wrap();
    t_sext();
    t_latency();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule